// File: doc/BRIEF.md
# Parallel Sampling Converter Digital Interface

This block is the digital control side of a 14-bit sampling converter that has a parallel output. A falling edge on the active-low convert-start input begins a conversion. On that edge the block captures the sample word, the mode select and the clip enable. The sample is a signed two's-complement value that the bench supplies in place of an analog front end. A conversion lasts a fixed sixteen clock cycles. During that time the active-low busy output is low.

The block adds a host-written offset to the captured sample. It can saturate the sum to full scale, and it reports an overrange bit. The result is presented in offset binary: the most significant bit of the two's-complement sum is inverted. Two modes decide how a finished result reaches the readable output register. In immediate mode the result is copied in before busy clears. In deferred mode busy clears as soon as the conversion ends, and the result is copied in on the next convert-start edge.

The host reads with chip-select and read held low. It writes the offset by pulsing the write strobe with chip-select low. Both use one shared bidirectional bus.

The control state machine has three states:
- ST_IDLE: busy is high. It moves to ST_CONV on an accepted start edge.
- ST_CONV: busy is low and sixteen cycles are counted. It moves to ST_LOAD in immediate mode, or back to ST_IDLE in deferred mode.
- ST_LOAD: the result is copied to the output register. It always moves to ST_IDLE.

Top module: `padc_if_core`

## Requirements
- R1: While rst_n is low, and right after it is released, busy_n is high and the output register, overrange bit and offset are all zero. A reset during a conversion aborts it.
- R2: A falling edge of cnv_n seen while busy_n is high starts a conversion. busy_n goes low from the following clock and stays low through 16 counted cycles.
- R3: cnv_n falling edges that arrive while busy_n is low are ignored. They neither restart the conversion nor recapture the sample.
- R4: Immediate mode (mode_sel=1): one cycle after the 16 counted cycles, the result is written into the output register and busy_n returns high in that same cycle, so busy_n is low for 17 cycles.
- R5: Deferred mode (mode_sel=0): busy_n returns high after exactly 16 cycles and the output register is left unchanged. The result moves into the output register on the next accepted cnv_n falling edge.
- R6: mode_sel, clip_en and sample_in are sampled only at the accepted start edge. Changes while busy have no effect on that conversion.
- R7: data_io drives the output register, and ovr_o drives the overrange bit, only while cs_n=0, rd_n=0 and wr=0. Otherwise both are high impedance.
- R8: With cs_n low, the word on data_io during a high pulse of wr is written into the offset register when wr falls. A pulse with cs_n high leaves the offset unchanged.
- R9: The result word is (sample + offset), both read as 14-bit two's complement, with bit 13 inverted (offset binary).
- R10: ovr_o is 1 whenever the sum is above 8191 or below -8192, whether clipping is on or off.
- R11: With clipping captured on, an overrange sum above 8191 gives 0x3FFF and one below -8192 gives 0x0000. With clipping off, the low 14 bits of the sum are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, held state while low |
| cnv_n | input | 1 | Convert start, falling edge starts a conversion |
| mode_sel | input | 1 | 1 = immediate load, 0 = deferred load |
| clip_en | input | 1 | Saturate overrange results |
| sample_in | input | 14 | Raw two's-complement sample |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr | input | 1 | Offset write strobe, active high |
| data_io | inout | 14 | Shared data bus |
| ovr_o | output | 1 | Overrange bit, tri-stated with the bus |
| busy_n | output | 1 | Low while a conversion is in progress |

## Verification
The bench targets the length of the busy window in each mode. A design that cleared busy one cycle early or late, or that loaded the output register early in deferred mode, would fail against the per-clock model. Start pulses inside a conversion are aimed at recapture bugs: they would change the result or stretch busy. The bench writes an offset with chip-select high to catch a write that is not qualified by chip-select. Sums just past either full-scale bound, with clipping on and off, expose wrap and saturation mistakes and an overrange bit that is tied to the clip setting. A reset partway through a conversion checks that the abort returns busy high and clears the registers.

// File: rtl/padc_pkg.sv
package padc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_LOAD = 2'd2
    } conv_state_e;

endpackage

// File: rtl/padc_fall_detect.sv
module padc_fall_detect #(
    parameter int            N    = 1,
    parameter logic [N-1:0]  INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] fall
);

    logic [N-1:0] lvl_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_d <= INIT;
        else        lvl_d <= lvl;
    end

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign fall[i] = lvl_d[i] & ~lvl[i];
    end

endmodule

// File: rtl/padc_result_calc.sv
module padc_result_calc #(
    parameter int DW = 14
) (
    input  logic [DW-1:0] raw,
    input  logic [DW-1:0] off,
    input  logic          clip,
    output logic [DW-1:0] word,
    output logic          ovr
);

    localparam int SW = DW + 1;
    localparam logic signed [SW-1:0] POS_FS = {2'b00, {(DW-1){1'b1}}};
    localparam logic signed [SW-1:0] NEG_FS = {2'b11, {(DW-1){1'b0}}};

    logic signed [SW-1:0] sum;
    logic                 hi;
    logic                 lo;

    always_comb begin
        sum  = {raw[DW-1], raw} + {off[DW-1], off};
        hi   = sum > POS_FS;
        lo   = sum < NEG_FS;
        ovr  = hi | lo;
        if (clip && hi)      word = '1;
        else if (clip && lo) word = '0;
        else                 word = {~sum[DW-1], sum[DW-2:0]};
    end

    // R11
    always_comb begin
        if (clip && ovr) begin
            clip_sat_chk: assert (word == '1 || word == '0);
        end
    end

endmodule

// File: rtl/padc_conv_fsm.sv
module padc_conv_fsm
    import padc_pkg::*;
#(
    parameter int DW       = 14,
    parameter int CONV_CYC = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_fall,
    input  logic          mode_in,
    input  logic          clip_in,
    input  logic [DW-1:0] sample_in,
    input  logic [DW-1:0] offset,
    output logic          busy_n,
    output logic [DW-1:0] out_word,
    output logic          out_ovr
);

    localparam int            CNT_W = $clog2(CONV_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYC - 1);

    conv_state_e    st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic [DW-1:0]  hold_q;
    logic           mode2_q;
    logic           clip_q;
    logic [DW-1:0]  res_q;
    logic           res_ovr_q;
    logic           pend_q;
    logic [DW-1:0]  out_q;
    logic           out_ovr_q;
    logic [DW-1:0]  calc_word;
    logic           calc_ovr;

    padc_result_calc #(.DW(DW)) u_calc (
        .raw  (hold_q),
        .off  (offset),
        .clip (clip_q),
        .word (calc_word),
        .ovr  (calc_ovr)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start_fall) st_d = ST_CONV;
            ST_CONV: if (cnt_q == LAST) st_d = mode2_q ? ST_LOAD : ST_IDLE;
            ST_LOAD: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            hold_q    <= '0;
            mode2_q   <= 1'b0;
            clip_q    <= 1'b0;
            res_q     <= '0;
            res_ovr_q <= 1'b0;
            pend_q    <= 1'b0;
            out_q     <= '0;
            out_ovr_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start_fall) begin
                        hold_q  <= sample_in;
                        mode2_q <= mode_in;
                        clip_q  <= clip_in;
                        cnt_q   <= '0;
                        if (pend_q) begin
                            out_q     <= res_q;
                            out_ovr_q <= res_ovr_q;
                            pend_q    <= 1'b0;
                        end
                    end
                end
                ST_CONV: begin
                    cnt_q <= cnt_q + CNT_W'(1);
                    if (cnt_q == LAST) begin
                        res_q     <= calc_word;
                        res_ovr_q <= calc_ovr;
                        pend_q    <= ~mode2_q;
                    end
                end
                ST_LOAD: begin
                    out_q     <= res_q;
                    out_ovr_q <= res_ovr_q;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        busy_n   = (st_q == ST_IDLE);
        out_word = out_q;
        out_ovr  = out_ovr_q;
    end

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_fall && busy_n) |=> !busy_n);

    // R3
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CONV && cnt_q != LAST) |=>
            (st_q == ST_CONV && cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R4
    load_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LOAD) |=> (busy_n && out_word == $past(res_q)));

    // R5
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CONV) |=> $stable(out_word));

endmodule

// File: rtl/padc_if_core.sv
module padc_if_core #(
    parameter int DW       = 14,
    parameter int CONV_CYC = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnv_n,
    input  logic          mode_sel,
    input  logic          clip_en,
    input  logic [DW-1:0] sample_in,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr,
    inout  wire  [DW-1:0] data_io,
    output logic          ovr_o,
    output logic          busy_n
);

    logic [1:0]    falls;
    logic          cnv_fall;
    logic          wr_fall;
    logic [DW-1:0] cap_q;
    logic [DW-1:0] offset_q;
    logic [DW-1:0] out_word;
    logic          out_ovr;
    logic          oe;

    padc_fall_detect #(.N(2), .INIT(2'b10)) u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   ({cnv_n, wr}),
        .fall  (falls)
    );

    assign cnv_fall = falls[1];
    assign wr_fall  = falls[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q    <= '0;
            offset_q <= '0;
        end else begin
            if (wr)               cap_q    <= data_io;
            if (wr_fall && !cs_n) offset_q <= cap_q;
        end
    end

    padc_conv_fsm #(.DW(DW), .CONV_CYC(CONV_CYC)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_fall (cnv_fall),
        .mode_in    (mode_sel),
        .clip_in    (clip_en),
        .sample_in  (sample_in),
        .offset     (offset_q),
        .busy_n     (busy_n),
        .out_word   (out_word),
        .out_ovr    (out_ovr)
    );

    assign oe      = ~cs_n & ~rd_n & ~wr;
    assign data_io = oe ? out_word : {DW{1'bz}};
    assign ovr_o   = oe ? out_ovr : 1'bz;

    // R8
    offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_fall && !cs_n) |=> $stable(offset_q));

endmodule

// File: tb/tb_padc_if_core.sv
module tb_padc_if_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnv_n = 1'b1;
    logic        mode_sel = 1'b0;
    logic        clip_en = 1'b0;
    logic [13:0] sample_in = '0;
    logic        cs_n = 1'b0;
    logic        rd_n = 1'b0;
    logic        wr = 1'b0;
    logic        tb_oe = 1'b0;
    logic [13:0] tb_d = '0;
    wire  [13:0] data_io;
    wire         ovr_o;
    wire         busy_n;

    assign data_io = tb_oe ? tb_d : 14'bz;

    always #4 clk = ~clk;

    padc_if_core dut (
        .clk(clk), .rst_n(rst_n), .cnv_n(cnv_n), .mode_sel(mode_sel),
        .clip_en(clip_en), .sample_in(sample_in), .cs_n(cs_n), .rd_n(rd_n),
        .wr(wr), .data_io(data_io), .ovr_o(ovr_o), .busy_n(busy_n)
    );

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R1";

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_st = 0, m_cnt = 0, m_hold = 0, m_off = 0, m_cap = 0;
    int m_res = 0, m_out = 0;
    bit m_mode2 = 0, m_clip = 0, m_rovr = 0, m_oovr = 0, m_pend = 0;
    bit p_cnv = 1, p_wr = 0;

    function automatic int calc(input int raw, input int off, input bit clip, output bit ov);
        int s;
        s  = raw + off;
        ov = (s > 8191) || (s < -8192);
        if (clip && s > 8191)  return 16383;
        if (clip && s < -8192) return 0;
        return (s & 16383) ^ 8192;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_hold = 0; m_off = 0; m_cap = 0;
            m_res = 0; m_out = 0; m_mode2 = 0; m_clip = 0;
            m_rovr = 0; m_oovr = 0; m_pend = 0; p_cnv = 1; p_wr = 0;
        end else begin
            bit cfall, wfall, ov;
            int r;
            cfall = p_cnv && !cnv_n;
            wfall = p_wr && !wr && !cs_n;
            if (m_st == 1) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    r = calc(m_hold, m_off, m_clip, ov);
                    m_res = r; m_rovr = ov;
                    if (m_mode2) m_st = 2;
                    else begin m_pend = 1; m_st = 0; end
                end
            end else if (m_st == 2) begin
                m_out = m_res; m_oovr = m_rovr; m_st = 0;
            end else if (cfall) begin
                m_hold = int'($signed(sample_in));
                m_mode2 = mode_sel; m_clip = clip_en;
                if (m_pend) begin m_out = m_res; m_oovr = m_rovr; m_pend = 0; end
                m_cnt = 16; m_st = 1;
            end
            if (wfall) m_off = m_cap;
            if (wr) m_cap = int'($signed(data_io));
            p_cnv = cnv_n;
            p_wr  = wr;
        end
    end

    // per-clock comparison, away from the edge
    always @(posedge clk) begin
        #3;
        chk(busy_n == (m_st == 0), cur_req, int'(busy_n), int'(m_st == 0));
        if (!cs_n && !rd_n && !wr) begin
            chk(int'(data_io) == m_out, cur_req, int'(data_io), m_out);
            chk(ovr_o == m_oovr, cur_req, int'(ovr_o), int'(m_oovr));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start(input int smp, input bit m2, input bit cl);
        @(negedge clk);
        sample_in = 14'(smp); mode_sel = m2; clip_en = cl; cnv_n = 1'b0;
        @(negedge clk);
        cnv_n = 1'b1;
    endtask

    task automatic wr_off(input int val, input bit cs);
        @(negedge clk);
        rd_n = 1'b1; tb_oe = 1'b1; tb_d = 14'(val); cs_n = cs; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        @(negedge clk);
        tb_oe = 1'b0; cs_n = 1'b0; rd_n = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        cyc(3);
        // R1 reset state
        chk(busy_n == 1'b1, "R1", int'(busy_n), 1);
        chk(data_io == 14'd0, "R1", int'(data_io), 0);
        rst_n = 1'b1;
        cyc(2);
        chk(data_io == 14'd0 && ovr_o == 1'b0, "R1", int'(data_io), 0);

        // R2 R4 R9 immediate mode
        cur_req = "R4";
        start(100, 1'b1, 1'b0);
        chk(busy_n == 1'b0, "R2", int'(busy_n), 0);
        cyc(17);
        chk(int'(data_io) == 8292, "R9", int'(data_io), 8292);

        // R5 deferred mode keeps old output
        cur_req = "R5";
        start(-200, 1'b0, 1'b0);
        cyc(20);
        chk(int'(data_io) == 8292, "R5", int'(data_io), 8292);
        start(0, 1'b1, 1'b0);
        chk(int'(data_io) == 7992, "R5", int'(data_io), 7992);
        cyc(17);
        chk(int'(data_io) == 8192, "R9", int'(data_io), 8192);

        // R3 start pulses during busy ignored; R6 inputs changed while busy
        cur_req = "R3";
        start(300, 1'b1, 1'b0);
        cyc(4);
        start(-4000, 1'b0, 1'b1);
        cur_req = "R6";
        mode_sel = 1'b0; sample_in = 14'd5;
        cyc(13);
        chk(int'(data_io) == (300 ^ 8192), "R3", int'(data_io), 300 ^ 8192);

        // R8 offset write, and a write with chip select high
        cur_req = "R8";
        wr_off(500, 1'b0);
        wr_off(77, 1'b1);
        start(1000, 1'b1, 1'b0);
        cyc(18);
        chk(int'(data_io) == 9692, "R8", int'(data_io), 9692);

        // R7 bus released while deselected
        cur_req = "R7";
        @(negedge clk);
        cs_n = 1'b1; tb_oe = 1'b1; tb_d = 14'h1234;
        @(negedge clk);
        chk(data_io == 14'h1234, "R7", int'(data_io), 'h1234);
        tb_oe = 1'b0; cs_n = 1'b0;

        // R10 R11 overrange with and without clipping
        cur_req = "R11";
        start(8000, 1'b1, 1'b1);
        cyc(18);
        chk(int'(data_io) == 16383, "R11", int'(data_io), 16383);
        chk(ovr_o == 1'b1, "R10", int'(ovr_o), 1);
        cur_req = "R10";
        start(8000, 1'b1, 1'b0);
        cyc(18);
        chk(int'(data_io) == 308, "R11", int'(data_io), 308);
        chk(ovr_o == 1'b1, "R10", int'(ovr_o), 1);
        wr_off(16384 - 500, 1'b0);
        start(-8000, 1'b1, 1'b1);
        cyc(18);
        chk(int'(data_io) == 0, "R11", int'(data_io), 0);
        chk(ovr_o == 1'b1, "R10", int'(ovr_o), 1);
        start(100, 1'b1, 1'b1);
        cyc(18);
        chk(ovr_o == 1'b0, "R10", int'(ovr_o), 0);

        // R1 reset in the middle of a conversion
        cur_req = "R1";
        start(50, 1'b1, 1'b0);
        cyc(5);
        rst_n = 1'b0;
        cyc(1);
        rst_n = 1'b1;
        cyc(2);
        chk(busy_n == 1'b1, "R1", int'(busy_n), 1);
        chk(data_io == 14'd0, "R1", int'(data_io), 0);
        start(10, 1'b1, 1'b0);
        cyc(18);
        chk(int'(data_io) == (10 ^ 8192), "R1", int'(data_io), 10 ^ 8192);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule